// File: doc/BRIEF.md
# Multi-Decoder Host-to-Device Address Translator

This block turns a host physical address into a device physical address. It uses a small set of programmable memory decoders, four by default. Each decoder describes one window of host address space with these values: a base, a size, a device-side skip, an interleave granularity code, an interleave ways code and a committed flag. The decoder values arrive as parallel inputs, because programming them happens elsewhere. A separate count input says how many decoders are live.

A request is accepted while the block is idle. The block then walks the live decoders one per clock, starting at the lowest index, and keeps a running device-address base as it goes. Each visited decoder first adds its skip to the running base. If the address falls outside that decoder's window, the decoder also adds its per-way share of capacity (its size divided by its way count). The first decoder whose window contains the address produces the result. The interleave selector bits are removed from the middle of the window offset, and what remains is added to the running base. The walk ends early in two cases. A decoder that is not committed ends it with a miss. A decoder with an unsupported ways code ends it with a miss and an error flag. A single-cycle response pulse carries the outcome.

The controller has three states. IDLE moves to SCAN on ACCEPT (request valid while idle). SCAN stays in SCAN on ADVANCE (a live, committed, well-formed decoder that does not match and is not the last one). SCAN moves to DONE on TERMINATE, which is a hit, a miss past the last live decoder, an uncommitted decoder, a bad ways code, or no live decoders at all. DONE always returns to IDLE on RELEASE.

Top module: `hpa_xlate_walker`

## Requirements
- R1: Only decoders with index below min(dec_count, 4) are examined. A dec_count of 0 gives a miss, and values above 4 are treated as 4.
- R2: Each base, size and skip is the 64-bit value {hi word, bits 31:28 of the low word, 28 zero bits}. Bits 27:0 of every low word have no effect on any result.
- R3: Decoders are visited in ascending index order, and the first matching decoder supplies the result. A decoder's skip is added to the running base before its own match test, so a matching decoder's skip is part of its result.
- R4: Reaching a decoder whose committed bit is 0 ends the walk with a miss and rsp_err = 0. Later decoders are not considered.
- R5: A decoder matches when addr >= base and (addr - base) < size.
- R6: A decoder that is visited and committed but does not match adds size >> IW to the running base before the next decoder is visited.
- R7: On a match, with offset = addr - base and L = 8 + IG, the result is rsp_dpa = running base + ((offset mod 2^L) | ((offset >> (L + IW)) << L)).
- R8: The ways code IW (4 bits) means 2^IW ways for values 0 to 4. A value from 5 to 15 on a visited, committed decoder ends the walk with a miss and rsp_err = 1.
- R9: A request is taken only when busy is 0. busy is 1 from the accept edge until the response pulse ends. A request raised while busy is 1 is ignored. rsp_valid is a one-cycle pulse seen j + 1 cycles after the accept edge, where j is the index of the decoder that ended the walk (0 when there are no live decoders).
- R10: rsp_hit and rsp_err are never both 1. rsp_dpa is 0 whenever rsp_hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_addr | input | 64 | Host physical address |
| busy | output | 1 | A walk is in progress or its response is being presented |
| dec_count | input | 3 | Number of live decoders |
| dec_base_hi | input | 128 | Per-decoder base, upper words (decoder i at bits 32i+31:32i) |
| dec_base_lo | input | 128 | Per-decoder base, lower words |
| dec_size_hi | input | 128 | Per-decoder size, upper words |
| dec_size_lo | input | 128 | Per-decoder size, lower words |
| dec_skip_hi | input | 128 | Per-decoder device skip, upper words |
| dec_skip_lo | input | 128 | Per-decoder device skip, lower words |
| dec_ig | input | 16 | Per-decoder granularity code (decoder i at bits 4i+3:4i) |
| dec_iw | input | 16 | Per-decoder ways code, log2 of way count |
| dec_committed | input | 4 | Per-decoder committed flag |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Translation found |
| rsp_err | output | 1 | Unsupported ways code met |
| rsp_dpa | output | 64 | Translated device physical address |

## Verification
Some properties are checked by assertions on every cycle. The response must be a single-cycle pulse that is followed by an idle cycle. A hit and an error must never appear together. An accepted request must always enter the scan state. The scan index must stay below the live decoder count. The compaction stage must always keep the low eight offset bits unchanged. Other behaviour needs directed scenarios to show it: the arithmetic of the running base across skipped decoders, the exact bits removed for each granularity and ways setting, the priority of the first match, the early stop at an uncommitted decoder, the clamping of the decoder count, the inertness of the low 28 bits of each low word, and the rejection of a request raised mid-walk.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } walk_state_t;

    // lowest offset bit that can carry interleave selection
    localparam int unsigned ILV_BASE_BIT = 8;
endpackage

// File: rtl/xlate_way_decode.sv
module xlate_way_decode #(
    parameter int IW_W    = 4,
    parameter int MAX_LOG = 4,
    parameter int SH_W    = 3
) (
    input  logic [IW_W-1:0] code,
    output logic            ok,
    output logic [SH_W-1:0] shift
);
    always_comb begin
        ok    = (code <= IW_W'(MAX_LOG));
        shift = ok ? code[SH_W-1:0] : '0;
    end
endmodule

// File: rtl/xlate_window.sv
module xlate_window #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    output logic          match,
    output logic [AW-1:0] offset
);
    always_comb begin
        offset = addr - base;
        match  = (addr >= base) && (offset < size);
    end
endmodule

// File: rtl/xlate_compact.sv
module xlate_compact #(
    parameter int AW    = 64,
    parameter int IG_W  = 4,
    parameter int SH_W  = 3,
    parameter int POS_W = 7
) (
    input  logic [AW-1:0]   offset,
    input  logic [IG_W-1:0] ig,
    input  logic [SH_W-1:0] shift,
    output logic [AW-1:0]   dense
);
    localparam int unsigned KEEP = xlate_pkg::ILV_BASE_BIT;

    logic [POS_W-1:0] lo_pos;
    logic [POS_W-1:0] hi_pos;
    logic [AW-1:0]    low_mask;

    always_comb begin
        lo_pos   = POS_W'(KEEP) + POS_W'(ig);
        hi_pos   = lo_pos + POS_W'(shift);
        low_mask = (AW'(1) << lo_pos) - AW'(1);
        dense    = (offset & low_mask) | ((offset >> hi_pos) << lo_pos);
    end

    // the bits below the minimum granule never move
    always_comb begin
        if (!$isunknown(offset)) begin
            assert_keep_low_R7: assert (dense[KEEP-1:0] == offset[KEEP-1:0]);
        end
    end
endmodule

// File: rtl/hpa_xlate_walker.sv
module hpa_xlate_walker #(
    parameter int NUM_DEC  = 4,
    parameter int WORD_W   = 32,
    parameter int GRAN_LSB = 28,
    parameter int IG_W     = 4,
    parameter int IW_W     = 4,
    parameter int CNT_W    = 3,
    parameter int MAX_LOG  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [2*WORD_W-1:0]       req_addr,
    output logic                      busy,
    input  logic [CNT_W-1:0]          dec_count,
    input  logic [NUM_DEC*WORD_W-1:0] dec_base_hi,
    input  logic [NUM_DEC*WORD_W-1:0] dec_base_lo,
    input  logic [NUM_DEC*WORD_W-1:0] dec_size_hi,
    input  logic [NUM_DEC*WORD_W-1:0] dec_size_lo,
    input  logic [NUM_DEC*WORD_W-1:0] dec_skip_hi,
    input  logic [NUM_DEC*WORD_W-1:0] dec_skip_lo,
    input  logic [NUM_DEC*IG_W-1:0]   dec_ig,
    input  logic [NUM_DEC*IW_W-1:0]   dec_iw,
    input  logic [NUM_DEC-1:0]        dec_committed,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic                      rsp_err,
    output logic [2*WORD_W-1:0]       rsp_dpa
);
    import xlate_pkg::*;

    localparam int AW     = 2 * WORD_W;
    localparam int HI_W   = WORD_W - GRAN_LSB;
    localparam int IDX_W  = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1;
    localparam int SH_W   = $clog2(MAX_LOG + 1);
    localparam int POS_W  = $clog2(AW) + 1;

    // ---------------- decoder unpacking ----------------
    logic [AW-1:0]   base_arr [NUM_DEC];
    logic [AW-1:0]   size_arr [NUM_DEC];
    logic [AW-1:0]   skip_arr [NUM_DEC];
    logic [IG_W-1:0] ig_arr   [NUM_DEC];
    logic [IW_W-1:0] iw_arr   [NUM_DEC];
    logic [NUM_DEC*3*GRAN_LSB-1:0] unused_lo_bits;

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_unpack
        assign base_arr[g] = {dec_base_hi[g*WORD_W +: WORD_W],
                              dec_base_lo[g*WORD_W+GRAN_LSB +: HI_W],
                              {GRAN_LSB{1'b0}}};
        assign size_arr[g] = {dec_size_hi[g*WORD_W +: WORD_W],
                              dec_size_lo[g*WORD_W+GRAN_LSB +: HI_W],
                              {GRAN_LSB{1'b0}}};
        assign skip_arr[g] = {dec_skip_hi[g*WORD_W +: WORD_W],
                              dec_skip_lo[g*WORD_W+GRAN_LSB +: HI_W],
                              {GRAN_LSB{1'b0}}};
        assign ig_arr[g]   = dec_ig[g*IG_W +: IG_W];
        assign iw_arr[g]   = dec_iw[g*IW_W +: IW_W];
        assign unused_lo_bits[g*3*GRAN_LSB +: 3*GRAN_LSB] =
            {dec_base_lo[g*WORD_W +: GRAN_LSB],
             dec_size_lo[g*WORD_W +: GRAN_LSB],
             dec_skip_lo[g*WORD_W +: GRAN_LSB]};
    end

    // ---------------- walk state ----------------
    walk_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [AW-1:0]    run_q, run_d;
    logic [AW-1:0]    addr_q, addr_d;
    logic [AW-1:0]    dpa_q, dpa_d;
    logic             hit_q, hit_d;
    logic             err_q, err_d;

    // ---------------- current decoder ----------------
    logic [CNT_W-1:0] n_act;
    logic             last_dec;
    logic             way_ok;
    logic [SH_W-1:0]  way_shift;
    logic             win_match;
    logic [AW-1:0]    win_off;
    logic [AW-1:0]    dense_off;
    logic [AW-1:0]    run_cur;
    logic [AW-1:0]    cap_share;

    always_comb begin
        n_act    = (dec_count > CNT_W'(NUM_DEC)) ? CNT_W'(NUM_DEC) : dec_count;
        last_dec = (CNT_W'(idx_q) == n_act - CNT_W'(1));
    end

    xlate_way_decode #(.IW_W(IW_W), .MAX_LOG(MAX_LOG), .SH_W(SH_W)) u_ways (
        .code  (iw_arr[idx_q]),
        .ok    (way_ok),
        .shift (way_shift)
    );

    xlate_window #(.AW(AW)) u_window (
        .addr   (addr_q),
        .base   (base_arr[idx_q]),
        .size   (size_arr[idx_q]),
        .match  (win_match),
        .offset (win_off)
    );

    xlate_compact #(.AW(AW), .IG_W(IG_W), .SH_W(SH_W), .POS_W(POS_W)) u_compact (
        .offset (win_off),
        .ig     (ig_arr[idx_q]),
        .shift  (way_shift),
        .dense  (dense_off)
    );

    always_comb begin
        run_cur   = run_q + skip_arr[idx_q];
        cap_share = size_arr[idx_q] >> way_shift;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        run_d   = run_q;
        addr_d  = addr_q;
        dpa_d   = dpa_q;
        hit_d   = hit_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin           // ACCEPT
                    state_d = ST_SCAN;
                    idx_d   = '0;
                    run_d   = '0;
                    addr_d  = req_addr;
                    dpa_d   = '0;
                    hit_d   = 1'b0;
                    err_d   = 1'b0;
                end
            end
            ST_SCAN: begin
                if (n_act == '0) begin
                    state_d = ST_DONE;         // TERMINATE: nothing live
                end else if (!dec_committed[idx_q]) begin
                    state_d = ST_DONE;         // TERMINATE: uncommitted
                end else if (!way_ok) begin
                    err_d   = 1'b1;
                    state_d = ST_DONE;         // TERMINATE: bad ways code
                end else if (win_match) begin
                    hit_d   = 1'b1;
                    dpa_d   = run_cur + dense_off;
                    state_d = ST_DONE;         // TERMINATE: hit
                end else if (last_dec) begin
                    state_d = ST_DONE;         // TERMINATE: exhausted
                end else begin
                    idx_d   = idx_q + IDX_W'(1); // ADVANCE
                    run_d   = run_cur + cap_share;
                end
            end
            ST_DONE: state_d = ST_IDLE;        // RELEASE
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            run_q   <= '0;
            addr_q  <= '0;
            dpa_q   <= '0;
            hit_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            run_q   <= run_d;
            addr_q  <= addr_d;
            dpa_q   <= dpa_d;
            hit_q   <= hit_d;
            err_q   <= err_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = (state_q != ST_IDLE);
        rsp_valid = (state_q == ST_DONE);
        rsp_hit   = rsp_valid && hit_q;
        rsp_err   = rsp_valid && err_q;
        rsp_dpa   = rsp_hit ? dpa_q : '0;
    end

    // ---------------- assertions ----------------
    assert_scan_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> ((n_act == '0) || (CNT_W'(idx_q) < n_act)));

    assert_accept_enters_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (state_q == ST_SCAN));

    assert_rsp_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    assert_hit_err_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_err));
endmodule

// File: tb/tb_hpa_xlate_walker.sv
module tb_hpa_xlate_walker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [63:0]  req_addr = '0;
    logic         busy;
    logic [2:0]   dec_count;
    logic [127:0] dec_base_hi, dec_base_lo, dec_size_hi, dec_size_lo;
    logic [127:0] dec_skip_hi, dec_skip_lo;
    logic [15:0]  dec_ig, dec_iw;
    logic [3:0]   dec_committed;
    logic         rsp_valid, rsp_hit, rsp_err;
    logic [63:0]  rsp_dpa;

    // bench-side decoder programming
    logic [63:0] b_base [4];
    logic [63:0] b_size [4];
    logic [63:0] b_skip [4];
    logic [3:0]  b_ig   [4];
    logic [3:0]  b_iw   [4];
    logic [3:0]  b_com;
    logic [2:0]  b_count;
    logic [27:0] b_junk;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            dec_base_hi[i*32 +: 32] = b_base[i][63:32];
            dec_base_lo[i*32 +: 32] = {b_base[i][31:28], b_junk};
            dec_size_hi[i*32 +: 32] = b_size[i][63:32];
            dec_size_lo[i*32 +: 32] = {b_size[i][31:28], b_junk};
            dec_skip_hi[i*32 +: 32] = b_skip[i][63:32];
            dec_skip_lo[i*32 +: 32] = {b_skip[i][31:28], b_junk};
            dec_ig[i*4 +: 4] = b_ig[i];
            dec_iw[i*4 +: 4] = b_iw[i];
        end
        dec_committed = b_com;
        dec_count     = b_count;
    end

    hpa_xlate_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .dec_count(dec_count),
        .dec_base_hi(dec_base_hi), .dec_base_lo(dec_base_lo),
        .dec_size_hi(dec_size_hi), .dec_size_lo(dec_size_lo),
        .dec_skip_hi(dec_skip_hi), .dec_skip_lo(dec_skip_lo),
        .dec_ig(dec_ig), .dec_iw(dec_iw), .dec_committed(dec_committed),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_dpa(rsp_dpa)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < 4; i++) begin
            b_base[i] = '0; b_size[i] = '0; b_skip[i] = '0;
            b_ig[i] = '0; b_iw[i] = '0;
        end
        b_com = 4'h0; b_count = 3'd4; b_junk = '0;
    endtask

    task automatic set_dec(input int i, input logic [63:0] base, input logic [63:0] size,
                           input logic [63:0] skip, input logic [3:0] ig, input logic [3:0] iw);
        b_base[i] = base; b_size[i] = size; b_skip[i] = skip;
        b_ig[i] = ig; b_iw[i] = iw; b_com[i] = 1'b1;
    endtask

    // expected outcome, from the requirement text
    task automatic model(input logic [63:0] a, output bit hit, output bit err,
                         output logic [63:0] dpa, output int lat);
        logic [63:0] run, off;
        int n, lp;
        hit = 0; err = 0; dpa = '0; lat = 1; run = '0;
        n = (b_count > 3'd4) ? 4 : int'(b_count);
        for (int i = 0; i < n; i++) begin
            lat = i + 1;
            run = run + b_skip[i];
            if (!b_com[i]) return;
            if (b_iw[i] > 4'd4) begin err = 1; return; end
            off = a - b_base[i];
            if (a >= b_base[i] && off < b_size[i]) begin
                lp  = 8 + int'(b_ig[i]);
                hit = 1;
                dpa = run + ((off & ((64'd1 << lp) - 64'd1)) |
                             ((off >> (lp + int'(b_iw[i]))) << lp));
                return;
            end
            run = run + (b_size[i] >> b_iw[i]);
        end
    endtask

    task automatic start(input logic [63:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // called at the first negedge after the accept edge
    task automatic wait_rsp(input int first, output int lat);
        lat = first;
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_and_check(input logic [63:0] a, input string req);
        bit eh, ee; logic [63:0] ed; int el, lat;
        model(a, eh, ee, ed, el);
        start(a);
        wait_rsp(0, lat);
        chk(lat == el, {req, " latency"}, 64'(lat), 64'(el));
        chk(rsp_hit == eh, {req, " hit"}, 64'(rsp_hit), 64'(eh));
        chk(rsp_err == ee, {req, " err"}, 64'(rsp_err), 64'(ee));
        chk(rsp_dpa == ed, {req, " dpa (R10 zero on miss)"}, rsp_dpa, ed);
        @(negedge clk);
    endtask

    task automatic expect_dpa(input logic [63:0] a, input logic [63:0] exp, input string req);
        int lat;
        start(a);
        wait_rsp(0, lat);
        chk(rsp_hit && rsp_dpa == exp, req, rsp_dpa, exp);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!rsp_valid && !busy, "R9 reset idle", {62'd0, rsp_valid, busy}, 64'd0);
    endtask

    task automatic t_plain_hit();
        clear_cfg();
        set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        b_count = 3'd1;
        expect_dpa(64'h1_0000_1234, 64'h1234, "R5 R7 direct hit");
        run_and_check(64'h1_0000_1234, "R5 direct");
    endtask

    task automatic t_interleave();
        clear_cfg();
        set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd1);
        b_count = 3'd1;
        expect_dpa(64'h1_0000_0345, 64'h145, "R7 R8 two-way removal");
        b_ig[0] = 4'd2; b_iw[0] = 4'd2;
        run_and_check(64'h1_0ABC_DEF0, "R7 four-way ig2");
        b_ig[0] = 4'd6; b_iw[0] = 4'd4;
        run_and_check(64'h1_0FED_CBA9, "R8 sixteen-way");
    endtask

    task automatic t_chain();
        clear_cfg();
        set_dec(0, 64'h1_0000_0000, 64'h2000_0000, 64'h1000_0000, 4'd0, 4'd1);
        set_dec(1, 64'h2_0000_0000, 64'h1000_0000, 64'h3000_0000, 4'd0, 4'd0);
        b_count = 3'd2;
        expect_dpa(64'h2_0000_0040, 64'h5000_0040, "R3 R6 running base");
        run_and_check(64'h2_0000_0040, "R6 chain");
        // overlap: decoder 1 covers decoder 0's window too
        b_base[1] = 64'h1_0000_0000;
        run_and_check(64'h1_0000_0800, "R3 first match wins");
    endtask

    task automatic t_boundary();
        clear_cfg();
        set_dec(0, 64'h3_0000_0000, 64'h3000_0000, 64'd0, 4'd1, 4'd0);
        b_count = 3'd1;
        run_and_check(64'h3_2FFF_FFFF, "R5 last byte");
        run_and_check(64'h3_3000_0000, "R5 one past end");
        run_and_check(64'h2_FFFF_FFFF, "R5 below base");
    endtask

    task automatic t_uncommit();
        clear_cfg();
        set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        set_dec(1, 64'h2_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        set_dec(2, 64'h4_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        b_com[1] = 1'b0;
        run_and_check(64'h4_0000_0010, "R4 stop at uncommitted");
    endtask

    task automatic t_bad_ways();
        clear_cfg();
        set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd5);
        run_and_check(64'h1_0000_0010, "R8 bad ways code");
        b_iw[0] = 4'd15;
        run_and_check(64'h5_0000_0010, "R8 bad ways nonmatch");
    endtask

    task automatic t_count();
        clear_cfg();
        set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 64'h1000_0000, 4'd0, 4'd0);
        set_dec(1, 64'h2_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        set_dec(2, 64'h3_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        set_dec(3, 64'h4_0000_0000, 64'h2000_0000, 64'h1000_0000, 4'd1, 4'd2);
        b_count = 3'd1;
        run_and_check(64'h2_0000_0010, "R1 count limits search");
        b_count = 3'd0;
        run_and_check(64'h1_0000_0010, "R1 zero live decoders");
        b_count = 3'd7;
        run_and_check(64'h4_1234_5678, "R1 count clamped");
    endtask

    task automatic t_low_bits();
        clear_cfg();
        set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 64'h2000_0000, 4'd0, 4'd0);
        set_dec(1, 64'h2_0000_0000, 64'h1000_0000, 64'h1000_0000, 4'd0, 4'd0);
        b_count = 3'd2;
        b_junk = 28'hABCDEF1;
        expect_dpa(64'h2_0000_0100, 64'h4000_0100, "R2 low word bits ignored");
        b_junk = 28'hFFFFFFF;
        run_and_check(64'h2_0FFF_FFFF, "R2 low bits all ones");
    endtask

    task automatic t_busy_ignore();
        int lat;
        clear_cfg();
        set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        set_dec(1, 64'h2_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        set_dec(2, 64'h3_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        set_dec(3, 64'h4_0000_0000, 64'h1000_0000, 64'd0, 4'd0, 4'd0);
        start(64'h4_0000_0020);
        chk(busy, "R9 busy during walk", 64'(busy), 64'd1);
        req_valid = 1'b1; req_addr = 64'h1_0000_0004;
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp(1, lat);
        chk(lat == 4, "R9 latency on last decoder", 64'(lat), 64'd4);
        chk(rsp_hit && rsp_dpa == 64'h3000_0020, "R9 mid-walk request ignored",
            rsp_dpa, 64'h3000_0020);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!rsp_valid && !busy, "R9 no second response", {62'd0, rsp_valid, busy}, 64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_hit();
        t_interleave();
        t_chain();
        t_boundary();
        t_uncommit();
        t_bad_ways();
        t_count();
        t_low_bits();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule